// File: doc/BRIEF.md
# Packed Halfword Multiply-Accumulate Unit

This execution unit splits each of its operands into 32-bit lanes. In each lane it forms signed 16x16 products from the low ("bottom") and high ("top") halfwords of operands `op_a` and `op_b`. It adds one or two of these products to a 32-bit accumulator lane taken from `acc_in`, or subtracts them from it. The sum is carried at full precision and then clamped once to the signed 32-bit range. A lane is bits [32i+31:32i], its bottom half is bits [15:0] of the lane and its top half is bits [31:16].

A 7-bit function code selects the pairing of halves (bottom with bottom, top with top, or crossed) and the add or subtract pattern. The surrounding pipeline supplies the code and the three operands together with `valid_in`. The registered result comes back one cycle later. A sticky saturation flag records any clamp in any lane until it is cleared. An unsupported code returns zero and raises an illegal-operation indication.

Top module: `pmac_unit`

## Requirements
- R1: One clock after a cycle with `valid_in` high, `valid_out` is high and `result_out` holds that operation's result. After a cycle with `valid_in` low, `valid_out` is low and `result_out` keeps its previous value.
- R2: Single-product codes add a product to the accumulator lane. 7'b0101101 adds bottom(a)*bottom(b). 7'b0110101 adds bottom(a)*top(b). 7'b0111101 adds top(a)*top(b).
- R3: Dual-sum codes add two products to the accumulator lane. 7'b0100100 adds bottom*bottom + top*top. 7'b0100101 adds top(a)*bottom(b) + bottom(a)*top(b).
- R4: Difference codes add a difference of two products to the accumulator lane. 7'b0101110 adds top*top - bottom*bottom. 7'b0110110 adds bottom*bottom - top*top. 7'b0111110 adds top(a)*bottom(b) - bottom(a)*top(b).
- R5: Subtract codes take a sum of two products away from the accumulator lane. 7'b0100110 subtracts bottom*bottom + top*top. 7'b0100111 subtracts top(a)*bottom(b) + bottom(a)*top(b).
- R6: A lane result above 0x7FFFFFFF is replaced by 0x7FFFFFFF, and one below -2^31 by 0x80000000. Either clamp sets `sat_flag` on the cycle the result appears.
- R7: When all four halves are 0x8000 the product sum is 2^31. It is combined exactly with the accumulator: accumulator -5 with code 0100100 gives 0x7FFFFFFB and no clamp, and accumulator 5 with code 0100110 gives 0x80000005 and no clamp.
- R8: With XLEN 64 the two lanes are computed independently. A clamp in either lane sets the single shared flag.
- R9: `sat_flag` stays set until reset or until `sat_clear` is high for a cycle. If a clamp occurs in the same cycle as `sat_clear`, the flag ends set.
- R10: Any other function code gives an all-zero result and `illegal_out` high, and leaves `sat_flag` unchanged. A legal code drives `illegal_out` low.
- R11: After reset, `valid_out`, `result_out`, `sat_flag` and `illegal_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation request this cycle |
| func_in | input | 7 | Function code |
| op_a | input | XLEN | Packed halfword operand a |
| op_b | input | XLEN | Packed halfword operand b |
| acc_in | input | XLEN | Accumulator lanes (previous destination) |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| valid_out | output | 1 | Result valid, one cycle after request |
| result_out | output | XLEN | Saturated lane results |
| sat_flag | output | 1 | Sticky saturation flag |
| illegal_out | output | 1 | Last operation had an unsupported code |

## Verification
The assertions assume that `valid_in`, `sat_clear` and `func_in` carry known values in every cycle after reset. They also assume that the operands are stable for the whole cycle in which they are sampled. The stimulus meets this by driving every input on the falling clock edge with fully specified values, and by holding `valid_in` and `sat_clear` low through reset. Idle cycles, clears with no operation, and clears that coincide with a clamping operation are all issued on purpose. This lets the latency, hold, sticky-flag and illegal-code properties each see both of their cases.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

    // Which halves feed a product: first letter = half of a, second = half of b
    typedef enum logic [1:0] {
        PR_BB = 2'd0,
        PR_BT = 2'd1,
        PR_TB = 2'd2,
        PR_TT = 2'd3
    } pair_e;

    typedef struct packed {
        logic  legal;
        pair_e sel1;
        logic  neg1;
        logic  use2;
        pair_e sel2;
        logic  neg2;
    } op_ctrl_t;

    localparam logic [6:0] FN_ADD_BB    = 7'b0101101;
    localparam logic [6:0] FN_ADD_BT    = 7'b0110101;
    localparam logic [6:0] FN_ADD_TT    = 7'b0111101;
    localparam logic [6:0] FN_ADD_SUM   = 7'b0100100;
    localparam logic [6:0] FN_ADD_XSUM  = 7'b0100101;
    localparam logic [6:0] FN_ADD_TMB   = 7'b0101110;
    localparam logic [6:0] FN_ADD_BMT   = 7'b0110110;
    localparam logic [6:0] FN_ADD_XDIF  = 7'b0111110;
    localparam logic [6:0] FN_SUB_SUM   = 7'b0100110;
    localparam logic [6:0] FN_SUB_XSUM  = 7'b0100111;

endpackage

// File: rtl/pmac_decode.sv
module pmac_decode
    import pmac_pkg::*;
(
    input  logic [6:0] func_i,
    output op_ctrl_t   ctrl_o
);

    always_comb begin
        ctrl_o = '{legal: 1'b1, sel1: PR_BB, neg1: 1'b0,
                   use2: 1'b0, sel2: PR_TT, neg2: 1'b0};
        case (func_i)
            FN_ADD_BB:   ctrl_o.sel1 = PR_BB;
            FN_ADD_BT:   ctrl_o.sel1 = PR_BT;
            FN_ADD_TT:   ctrl_o.sel1 = PR_TT;
            FN_ADD_SUM:  ctrl_o.use2 = 1'b1;
            FN_ADD_XSUM: begin
                ctrl_o.sel1 = PR_TB;
                ctrl_o.sel2 = PR_BT;
                ctrl_o.use2 = 1'b1;
            end
            FN_ADD_TMB: begin
                ctrl_o.sel1 = PR_TT;
                ctrl_o.sel2 = PR_BB;
                ctrl_o.use2 = 1'b1;
                ctrl_o.neg2 = 1'b1;
            end
            FN_ADD_BMT: begin
                ctrl_o.use2 = 1'b1;
                ctrl_o.neg2 = 1'b1;
            end
            FN_ADD_XDIF: begin
                ctrl_o.sel1 = PR_TB;
                ctrl_o.sel2 = PR_BT;
                ctrl_o.use2 = 1'b1;
                ctrl_o.neg2 = 1'b1;
            end
            FN_SUB_SUM: begin
                ctrl_o.neg1 = 1'b1;
                ctrl_o.use2 = 1'b1;
                ctrl_o.neg2 = 1'b1;
            end
            FN_SUB_XSUM: begin
                ctrl_o.sel1 = PR_TB;
                ctrl_o.sel2 = PR_BT;
                ctrl_o.neg1 = 1'b1;
                ctrl_o.use2 = 1'b1;
                ctrl_o.neg2 = 1'b1;
            end
            default:     ctrl_o.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmac_lane.sv
module pmac_lane
    import pmac_pkg::*;
#(
    parameter int LW = 32
) (
    input  logic [LW-1:0] a_i,
    input  logic [LW-1:0] b_i,
    input  logic [LW-1:0] c_i,
    input  pair_e         sel1_i,
    input  logic          neg1_i,
    input  logic          use2_i,
    input  pair_e         sel2_i,
    input  logic          neg2_i,
    output logic [LW-1:0] res_o,
    output logic          clamp_o
);

    localparam int HW = LW / 2;
    localparam int SW = LW + 2;
    localparam logic signed [SW-1:0] MAX_S = $signed({3'b000, {(LW-1){1'b1}}});
    localparam logic signed [SW-1:0] MIN_S = $signed({3'b111, {(LW-1){1'b0}}});

    logic signed [HW-1:0] x1, y1, x2, y2;
    logic signed [LW-1:0] prod1, prod2;
    logic signed [SW-1:0] term1, term2, sum;

    // Operand halves are steered into two multipliers per lane
    always_comb begin
        x1 = sel1_i[1] ? a_i[LW-1:HW] : a_i[HW-1:0];
        y1 = sel1_i[0] ? b_i[LW-1:HW] : b_i[HW-1:0];
        x2 = sel2_i[1] ? a_i[LW-1:HW] : a_i[HW-1:0];
        y2 = sel2_i[0] ? b_i[LW-1:HW] : b_i[HW-1:0];
    end

    assign prod1 = x1 * y1;
    assign prod2 = x2 * y2;

    always_comb begin
        term1 = SW'(prod1);
        term2 = use2_i ? SW'(prod2) : '0;
        if (neg1_i) term1 = -term1;
        if (neg2_i) term2 = -term2;
        sum = $signed({{2{c_i[LW-1]}}, c_i}) + term1 + term2;
        clamp_o = 1'b0;
        res_o   = sum[LW-1:0];
        if (sum > MAX_S) begin
            res_o   = MAX_S[LW-1:0];
            clamp_o = 1'b1;
        end else if (sum < MIN_S) begin
            res_o   = MIN_S[LW-1:0];
            clamp_o = 1'b1;
        end
    end

endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [6:0]      func_in,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] acc_in,
    input  logic            sat_clear,
    output logic            valid_out,
    output logic [XLEN-1:0] result_out,
    output logic            sat_flag,
    output logic            illegal_out
);

    localparam int LANE_W = 32;
    localparam int LANES  = XLEN / LANE_W;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            sat;
        logic            ill;
    } state_t;

    op_ctrl_t        ctrl;
    logic [XLEN-1:0] lane_res;
    logic [LANES-1:0] lane_clamp;
    state_t          st_d, st_q;

    pmac_decode u_dec (
        .func_i (func_in),
        .ctrl_o (ctrl)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmac_lane #(.LW(LANE_W)) u_lane (
            .a_i     (op_a  [g*LANE_W +: LANE_W]),
            .b_i     (op_b  [g*LANE_W +: LANE_W]),
            .c_i     (acc_in[g*LANE_W +: LANE_W]),
            .sel1_i  (ctrl.sel1),
            .neg1_i  (ctrl.neg1),
            .use2_i  (ctrl.use2),
            .sel2_i  (ctrl.sel2),
            .neg2_i  (ctrl.neg2),
            .res_o   (lane_res[g*LANE_W +: LANE_W]),
            .clamp_o (lane_clamp[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_in;
        if (sat_clear) st_d.sat = 1'b0;
        if (valid_in) begin
            if (ctrl.legal) begin
                st_d.res = lane_res;
                st_d.ill = 1'b0;
                if (|lane_clamp) st_d.sat = 1'b1;
            end else begin
                st_d.res = '0;
                st_d.ill = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_out   = st_q.vld;
    assign result_out  = st_q.res;
    assign sat_flag    = st_q.sat;
    assign illegal_out = st_q.ill;

    // R1: result follows a request by one cycle
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R1: idle cycles produce no valid and keep the result
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && $stable(result_out)));

    // R6: a lane clamp on a legal request shows on the flag
    p_clamp_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && ctrl.legal && (|lane_clamp)) |=> sat_flag);

    // R9: the flag is sticky without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clear) |=> sat_flag);

    // R9: a clear with no request empties the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clear && !valid_in) |=> !sat_flag);

    // R10: unsupported code returns zero and flags illegal
    p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !ctrl.legal) |=> (illegal_out && result_out == '0));

    // R10: unsupported code leaves the flag alone
    p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !ctrl.legal && !sat_clear) |=> $stable(sat_flag));

endmodule

// File: tb/pmac_unit_tb.sv
`timescale 1ns/1ps
module pmac_unit_tb_top;

    localparam int XLEN  = 64;
    localparam int LANES = XLEN / 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_in = 1'b0;
    logic [6:0]      func_in = '0;
    logic [XLEN-1:0] op_a = '0, op_b = '0, acc_in = '0;
    logic            sat_clear = 1'b0;
    logic            valid_out, sat_flag, illegal_out;
    logic [XLEN-1:0] result_out;

    always #2 clk = ~clk;

    pmac_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .func_in(func_in),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in), .sat_clear(sat_clear),
        .valid_out(valid_out), .result_out(result_out),
        .sat_flag(sat_flag), .illegal_out(illegal_out)
    );

    typedef struct {
        logic [XLEN-1:0] res;
        logic            sat;
        logic            ill;
        string           tag;
    } exp_t;

    exp_t            sb_q[$];
    int              n_chk = 0;
    int              n_bad = 0;
    logic            sat_m = 1'b0;
    logic [XLEN-1:0] last_res = '0;
    bit              done = 1'b0;

    logic [6:0] legal_codes [10] = '{7'b0101101, 7'b0110101, 7'b0111101,
        7'b0100100, 7'b0100101, 7'b0101110, 7'b0110110, 7'b0111110,
        7'b0100110, 7'b0100111};

    // Reference lane model from the requirement text
    function automatic logic [31:0] ref_lane(input logic [6:0] f,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
            output logic sat, output logic legal);
        longint al, ah, bl, bh, cc, bb, bt, tb, tt, s;
        al = longint'($signed(a[15:0]));  ah = longint'($signed(a[31:16]));
        bl = longint'($signed(b[15:0]));  bh = longint'($signed(b[31:16]));
        cc = longint'($signed(c));
        bb = al*bl; bt = al*bh; tb = ah*bl; tt = ah*bh;
        legal = 1'b1; sat = 1'b0;
        case (f)
            7'b0101101: s = cc + bb;
            7'b0110101: s = cc + bt;
            7'b0111101: s = cc + tt;
            7'b0100100: s = cc + bb + tt;
            7'b0100101: s = cc + tb + bt;
            7'b0101110: s = cc + tt - bb;
            7'b0110110: s = cc + bb - tt;
            7'b0111110: s = cc + tb - bt;
            7'b0100110: s = cc - (bb + tt);
            7'b0100111: s = cc - (tb + bt);
            default: begin legal = 1'b0; s = 0; end
        endcase
        if (s > 64'sd2147483647)       begin s = 64'sd2147483647;  sat = 1'b1; end
        else if (s < -64'sd2147483648) begin s = -64'sd2147483648; sat = 1'b1; end
        return s[31:0];
    endfunction

    task automatic report(input string tag, input logic [XLEN-1:0] act,
                          input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one request and queues the expected outcome
    task automatic drive(input logic [6:0] f, input logic [XLEN-1:0] a,
            input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
            input logic clr, input string tag);
        exp_t e;
        logic any_sat, lgl, ls;
        logic [XLEN-1:0] r;
        any_sat = 1'b0; lgl = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            r[i*32 +: 32] = ref_lane(f, a[i*32 +: 32], b[i*32 +: 32],
                                     c[i*32 +: 32], ls, lgl);
            any_sat |= ls;
        end
        if (clr) sat_m = 1'b0;
        if (lgl) begin
            e.res = r;
            if (any_sat) sat_m = 1'b1;
        end else begin
            e.res = '0;
        end
        e.sat = sat_m; e.ill = !lgl; e.tag = tag;
        sb_q.push_back(e);
        valid_in = 1'b1; func_in = f; op_a = a; op_b = b; acc_in = c;
        sat_clear = clr;
        @(negedge clk);
        valid_in = 1'b0; sat_clear = 1'b0;
    endtask

    task automatic clear_only();
        sat_clear = 1'b1; sat_m = 1'b0;
        @(negedge clk);
        sat_clear = 1'b0;
        report("R9 clear", {{(XLEN-1){1'b0}}, sat_flag}, '0);
    endtask

    // Monitor: compares each produced result with the queue head
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1: unexpected valid_out actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                report(e.tag, result_out, e.res);
                if (sat_flag !== e.sat || illegal_out !== e.ill) begin
                    n_bad++;
                    $display("FAIL %s flags: actual sat=%b ill=%b expected sat=%b ill=%b",
                             e.tag, sat_flag, illegal_out, e.sat, e.ill);
                end
                last_res = result_out;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [31:0] M16 = 32'h8000_8000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        report("R11 reset", {result_out[XLEN-4:0], valid_out, sat_flag, illegal_out}, '0);

        // R2 single products, mixed signs per lane
        drive(7'b0101101, {32'hFFFE_0003, 32'h0005_FFF9}, {32'h0004_0007, 32'hFFFD_0002}, {32'd100, 32'hFFFF_FF00}, 1'b0, "R2 bb");
        drive(7'b0110101, {32'hFFFE_0003, 32'h0005_FFF9}, {32'h0004_0007, 32'hFFFD_0002}, {32'd100, 32'hFFFF_FF00}, 1'b0, "R2 bt");
        drive(7'b0111101, {32'h1234_0003, 32'h8001_FFF9}, {32'h0100_0007, 32'h7FFF_0002}, {32'd0, 32'd7}, 1'b0, "R2 tt");
        // R3 dual sums
        drive(7'b0100100, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd1, 32'd2}, 1'b0, "R3 sum");
        drive(7'b0100101, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd1, 32'd2}, 1'b0, "R3 xsum");
        // R4 differences
        drive(7'b0101110, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd50, 32'hFFFF_FFF0}, 1'b0, "R4 tmb");
        drive(7'b0110110, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd50, 32'hFFFF_FFF0}, 1'b0, "R4 bmt");
        drive(7'b0111110, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd50, 32'hFFFF_FFF0}, 1'b0, "R4 xdif");
        // R5 subtract from accumulator
        drive(7'b0100110, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd1000, 32'hFFFF_FC00}, 1'b0, "R5 sub");
        drive(7'b0100111, {32'h0010_0020, 32'hFFF0_0030}, {32'h0003_0004, 32'h0005_FFFA}, {32'd1000, 32'hFFFF_FC00}, 1'b0, "R5 xsub");

        // R1 idle hold
        @(negedge clk);
        report("R1 idle valid", {{(XLEN-1){1'b0}}, valid_out}, '0);
        report("R1 idle hold", result_out, last_res);

        // R6 positive and negative clamps, flag sets
        drive(7'b0101101, {32'h0000_7FFF, 32'h0}, {32'h0000_7FFF, 32'h0}, {32'h7FFF_FFF0, 32'h0}, 1'b0, "R6 high");
        clear_only();
        drive(7'b0100110, {32'h0, 32'h7FFF_7FFF}, {32'h0, 32'h7FFF_7FFF}, {32'h0, 32'h8000_0010}, 1'b0, "R6 low");
        clear_only();

        // R7 all halves at -32768
        drive(7'b0100100, {2{M16}}, {2{M16}}, {32'hFFFF_FFFB, 32'hFFFF_FFFB}, 1'b0, "R7 add neg acc");
        drive(7'b0100110, {2{M16}}, {2{M16}}, {32'd5, 32'd5}, 1'b0, "R7 sub pos acc");
        drive(7'b0100101, {2{M16}}, {2{M16}}, {32'd0, 32'd0}, 1'b0, "R7 add clamp");
        clear_only();
        drive(7'b0100111, {2{M16}}, {2{M16}}, {32'hFFFF_FFFF, 32'd3}, 1'b0, "R7 sub clamp");
        clear_only();

        // R8 lane independence: only upper lane clamps
        drive(7'b0111101, {32'h7FFF_0000, 32'h0002_0000}, {32'h7FFF_0000, 32'h0003_0000}, {32'h7FFF_0000, 32'd9}, 1'b0, "R8 upper clamp");
        clear_only();
        drive(7'b0111101, {32'h0002_0000, 32'h7FFF_0000}, {32'h0003_0000, 32'h7FFF_0000}, {32'd9, 32'h7FFF_0000}, 1'b0, "R8 lower clamp");

        // R10 illegal code with flag set, then with flag clear
        drive(7'b0000000, {2{32'h1234_5678}}, {2{32'h1111_2222}}, {2{32'd77}}, 1'b0, "R10 illegal flag set");
        clear_only();
        drive(7'b1111111, {2{32'h7FFF_7FFF}}, {2{32'h7FFF_7FFF}}, {2{32'h7FFF_FFFF}}, 1'b0, "R10 illegal flag clear");
        drive(7'b0101101, {2{32'h0002_0002}}, {2{32'h0003_0003}}, {2{32'd1}}, 1'b0, "R10 legal after illegal");

        // R9 clamp and clear in the same cycle: set wins
        drive(7'b0101101, {2{32'h0000_7FFF}}, {2{32'h0000_7FFF}}, {2{32'h7FFF_0000}}, 1'b1, "R9 set over clear");
        drive(7'b0101101, {2{32'h0000_0001}}, {2{32'h0000_0001}}, {2{32'd0}}, 1'b0, "R9 sticky");
        drive(7'b0101101, {2{32'h0000_0001}}, {2{32'h0000_0001}}, {2{32'd0}}, 1'b1, "R9 clear with op");

        // Random legal traffic across all codes (R2 R3 R4 R5 R6)
        for (int k = 0; k < 60; k++) begin
            logic [XLEN-1:0] ra, rb, rc;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            rc = {$urandom(), $urandom()};
            drive(legal_codes[$urandom_range(9, 0)], ra, rb, rc,
                  ($urandom_range(3, 0) == 0), "R2 R3 R4 R5 R6 random");
        end

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1: actual %0d pending expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule